// File: doc/BRIEF.md
# HDLC Data Link Transmitter

This block turns a queue of message octets into a bit-serial HDLC-style data link stream. An external FIFO presents octets with a one-bit end-of-message tag. While nothing is queued, the line carries back-to-back flag octets. As soon as a byte is waiting at an octet boundary, the flag stream ends and the message bytes go out with zero-bit insertion. When the tagged last byte has gone, an optional 16-bit frame check sequence follows, then two flag octets, and a one-cycle completion pulse marks the end of the second flag.

The serial rate is set by a per-bit enable from the surrounding framer. Exactly one line bit leaves on each clock in which that enable is high. If the FIFO runs dry before a tagged last byte has been sent, the frame is abandoned: an all-ones octet is sent, an underrun pulse is raised and the line returns to idle flags. Frames queued one behind another are separated only by the two closing flags of the earlier frame.

Top module: `hdlc_link_tx`

## Requirements
- R1: While reset is held, tx_bit is 1, and fifo_rd, msg_done and underrun are 0.
- R2: With no message in progress and the FIFO empty, the line carries the flag 0x7E repeatedly, bit 0 first. The first enabled bit after reset is bit 0 of a flag.
- R3: When the FIFO is non-empty at the end of an idle flag octet, the next octet is the first message byte. fifo_rd is high for exactly one cycle per byte taken. That cycle also has bit_en high and the FIFO non-empty.
- R4: Message bytes are sent bit 0 first, in FIFO order, up to and including the byte whose fifo_eom tag is 1.
- R5: If fcs_en is 1 when the tagged byte finishes, two check octets follow. They hold the ones complement of a reflected CRC-16 (polynomial 0x8408 in reflected form, preset 0xFFFF) taken over the message bits, and the low octet goes first. If fcs_en is 0, none are sent.
- R6: A 0 is inserted after any five consecutive 1s of the message or check octets, so any byte value (0x7E and 0xFF included) reaches the far end intact. Flag and abort octets carry no inserted bits.
- R7: After the last byte or check octet, exactly two flags are sent. msg_done is a one-cycle pulse in the cycle in which tx_bit shows the last bit of the second flag.
- R8: If the FIFO holds a byte when the second closing flag ends, the next message starts at once, with exactly two flags between the frames. Otherwise idle flags follow.
- R9: tx_bit changes only on a clock edge at which bit_en is high, and it holds its value otherwise.
- R10: If the FIFO is empty when an untagged message byte finishes, the octet 0xFF (eight 1s, no inserted bit) is sent instead. underrun pulses for one cycle, no msg_done is produced, and idle flags follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One line bit is sent on each clock with this high |
| fcs_en | input | 1 | Append the check sequence to the current frame |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_eom | input | 1 | Head byte is the last byte of its message |
| fifo_rd | output | 1 | Pops the head byte at this clock edge |
| tx_bit | output | 1 | Serial line bit |
| msg_done | output | 1 | One-cycle pulse at the end of the second closing flag |
| underrun | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
A stale ones counter or a wrong octet kind shows up at tx_bit within one octet as a missing or extra inserted zero, and a receiver then sees a bad length, a false flag or an abort. The bench decodes the captured line independently and finds these within the frame in which they happen. A CRC state that is not preset between frames corrupts the check octets of the very next frame. A miscounted closing-flag counter moves the msg_done pulse away from the end of the second flag and changes the flag count between back-to-back frames, both compared bit-exactly against the decoded flag positions.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   // kind of octet currently in the shift register
   typedef enum logic [1:0] {
      OCT_FLAG  = 2'd0,
      OCT_DATA  = 2'd1,
      OCT_FCS   = 2'd2,
      OCT_ABORT = 2'd3
   } oct_kind_e;

   localparam logic [7:0] FLAG_OCTET  = 8'h7E;
   localparam logic [7:0] ABORT_OCTET = 8'hFF;

endpackage

// File: rtl/hdlc_fcs_gen.sv
// Bit-serial reflected CRC engine; fcs_next is the complemented value
// including the bit presented on din this cycle.
module hdlc_fcs_gen #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   POLY = 16'h8408,
   parameter logic [W-1:0]   INIT = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         step,
   input  logic         din,
   output logic [W-1:0] fcs_next
);

   logic [W-1:0] crc_q;
   logic [W-1:0] crc_adv;
   logic         fb;

   assign fb = crc_q[0] ^ din;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
         assign crc_adv[i] = fb & POLY[i];
      end else begin : g_mid
         assign crc_adv[i] = crc_q[i+1] ^ (fb & POLY[i]);
      end
   end

   assign fcs_next = ~crc_adv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q <= INIT;
      end else if (init) begin
         crc_q <= INIT;
      end else if (step) begin
         crc_q <= crc_adv;
      end
   end

endmodule

// File: rtl/hdlc_zero_ins.sv
// Counts consecutive 1s of stuffable bits; flags when a 0 is due.
module hdlc_zero_ins #(
   parameter int RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic bit_out,
   input  logic count_en,
   output logic ins_due
);

   localparam int CW = $clog2(RUN + 1);

   logic [CW-1:0] ones_q;

   assign ins_due = (ones_q == CW'(RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (step) begin
         if (ins_due)
            ones_q <= '0;
         else if (count_en && bit_out)
            ones_q <= ones_q + CW'(1);
         else
            ones_q <= '0;
      end
   end

endmodule

// File: rtl/hdlc_link_tx.sv
module hdlc_link_tx
   import hdlc_tx_pkg::*;
#(
   parameter int             OCT_W       = 8,
   parameter int             FCS_W       = 16,
   parameter logic [FCS_W-1:0] FCS_POLY  = 16'h8408,
   parameter bit             HAS_FCS     = 1'b1,
   parameter int             STUFF_RUN   = 5,
   parameter int             CLOSE_FLAGS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             fcs_en,
   input  logic             fifo_empty,
   input  logic [OCT_W-1:0] fifo_data,
   input  logic             fifo_eom,
   output logic             fifo_rd,
   output logic             tx_bit,
   output logic             msg_done,
   output logic             underrun
);

   localparam int IDX_W    = $clog2(OCT_W);
   localparam int FCS_OCTS = FCS_W / OCT_W;
   localparam int FCNT_W   = $clog2(FCS_OCTS + 1);
   localparam int CL_W     = $clog2(CLOSE_FLAGS + 1);

   // elaboration-time parameter checks
   if (OCT_W != 8) begin : g_bad_oct
      $error("hdlc_link_tx: OCT_W must be 8");
   end
   if ((FCS_W % OCT_W) != 0 || FCS_W < OCT_W) begin : g_bad_fcs
      $error("hdlc_link_tx: FCS_W must be a multiple of OCT_W");
   end
   if (STUFF_RUN < 1 || STUFF_RUN > 5) begin : g_bad_run
      $error("hdlc_link_tx: STUFF_RUN must be 1..5");
   end
   if (CLOSE_FLAGS < 1) begin : g_bad_close
      $error("hdlc_link_tx: CLOSE_FLAGS must be at least 1");
   end

   oct_kind_e          kind_q, n_kind;
   logic [OCT_W-1:0]   oct_q, n_oct;
   logic [IDX_W-1:0]   idx_q;
   logic               eom_q, n_eom;
   logic [FCS_W-1:0]   fcs_q, n_fcs;
   logic [FCNT_W-1:0]  fcnt_q, n_fcnt;
   logic [CL_W-1:0]    close_q, n_close;

   logic               stuff_due;
   logic               adv;
   logic               oct_end;
   logic               cur_bit;
   logic               stuffable;
   logic               take;
   logic               done_p;
   logic               undr_p;
   logic               pick_next;
   logic               fcs_on;
   logic [FCS_W-1:0]   fcs_new;

   assign cur_bit   = oct_q[idx_q];
   assign adv       = bit_en && !stuff_due;
   assign oct_end   = adv && (idx_q == IDX_W'(OCT_W - 1));
   assign stuffable = (kind_q == OCT_DATA) || (kind_q == OCT_FCS);

   hdlc_zero_ins #(
      .RUN (STUFF_RUN)
   ) i_zero_ins (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (bit_en),
      .bit_out  (cur_bit),
      .count_en (stuffable),
      .ins_due  (stuff_due)
   );

   // check-sequence variant chosen by parameter
   if (HAS_FCS) begin : g_fcs
      hdlc_fcs_gen #(
         .W    (FCS_W),
         .POLY (FCS_POLY),
         .INIT ({FCS_W{1'b1}})
      ) i_fcs_gen (
         .clk      (clk),
         .rst_n    (rst_n),
         .init     (bit_en && (kind_q != OCT_DATA)),
         .step     (adv && (kind_q == OCT_DATA)),
         .din      (cur_bit),
         .fcs_next (fcs_new)
      );
      assign fcs_on = fcs_en;
   end else begin : g_no_fcs
      assign fcs_new = '0;
      assign fcs_on  = 1'b0;
   end

   // choice of the octet that follows the current one
   always_comb begin
      n_kind    = kind_q;
      n_oct     = FLAG_OCTET;
      n_eom     = eom_q;
      n_fcs     = fcs_q;
      n_fcnt    = fcnt_q;
      n_close   = close_q;
      take      = 1'b0;
      done_p    = 1'b0;
      undr_p    = 1'b0;
      pick_next = 1'b0;
      unique case (kind_q)
         OCT_FLAG: begin
            if (close_q > CL_W'(1)) begin
               n_close = close_q - CL_W'(1);
            end else begin
               done_p    = (close_q == CL_W'(1));
               n_close   = '0;
               pick_next = 1'b1;
            end
         end
         OCT_DATA: begin
            if (eom_q) begin
               if (fcs_on) begin
                  n_kind = OCT_FCS;
                  n_oct  = fcs_new[OCT_W-1:0];
                  n_fcs  = fcs_new >> OCT_W;
                  n_fcnt = FCNT_W'(FCS_OCTS - 1);
               end else begin
                  n_kind  = OCT_FLAG;
                  n_close = CL_W'(CLOSE_FLAGS);
               end
            end else if (fifo_empty) begin
               n_kind = OCT_ABORT;
               n_oct  = ABORT_OCTET;
               undr_p = 1'b1;
            end else begin
               pick_next = 1'b1;
            end
         end
         OCT_FCS: begin
            if (fcnt_q != '0) begin
               n_oct  = fcs_q[OCT_W-1:0];
               n_fcs  = fcs_q >> OCT_W;
               n_fcnt = fcnt_q - FCNT_W'(1);
            end else begin
               n_kind  = OCT_FLAG;
               n_close = CL_W'(CLOSE_FLAGS);
            end
         end
         default: begin
            n_kind  = OCT_FLAG;
            n_close = '0;
         end
      endcase
      if (pick_next) begin
         if (!fifo_empty) begin
            n_kind = OCT_DATA;
            n_oct  = fifo_data;
            n_eom  = fifo_eom;
            take   = 1'b1;
         end else begin
            n_kind = OCT_FLAG;
         end
      end
   end

   assign fifo_rd = oct_end && take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= OCT_FLAG;
         oct_q    <= FLAG_OCTET;
         idx_q    <= '0;
         eom_q    <= 1'b0;
         fcs_q    <= '0;
         fcnt_q   <= '0;
         close_q  <= '0;
         tx_bit   <= 1'b1;
         msg_done <= 1'b0;
         underrun <= 1'b0;
      end else begin
         msg_done <= 1'b0;
         underrun <= 1'b0;
         if (bit_en)
            tx_bit <= stuff_due ? 1'b0 : cur_bit;
         if (adv) begin
            if (oct_end) begin
               idx_q    <= '0;
               kind_q   <= n_kind;
               oct_q    <= n_oct;
               eom_q    <= n_eom;
               fcs_q    <= n_fcs;
               fcnt_q   <= n_fcnt;
               close_q  <= n_close;
               msg_done <= done_p;
               underrun <= undr_p;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/hdlc_link_tx_chk.sv
module hdlc_link_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic fifo_empty,
   input logic fifo_rd,
   input logic tx_bit,
   input logic msg_done,
   input logic underrun
);

   // R9
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_bit));

   // R3
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> (bit_en && !fifo_empty));

   // R3
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |=> !fifo_rd);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |=> !msg_done);

   // R7
   done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |-> $past(bit_en));

   // R10
   undr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |-> !msg_done);

   // R10
   undr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> !underrun);

endmodule

bind hdlc_link_tx hdlc_link_tx_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bit_en     (bit_en),
   .fifo_empty (fifo_empty),
   .fifo_rd    (fifo_rd),
   .tx_bit     (tx_bit),
   .msg_done   (msg_done),
   .underrun   (underrun)
);

// File: tb/test_hdlc_link_tx.sv
`timescale 1ns/1ps
module test_hdlc_link_tx;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_en;
   logic       fcs_en;
   logic       fifo_empty;
   logic [7:0] fifo_data;
   logic       fifo_eom;
   logic       fifo_rd;
   logic       tx_bit;
   logic       msg_done;
   logic       underrun;

   always #4 clk = ~clk;

   hdlc_link_tx i_hdlc_link_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .fcs_en     (fcs_en),
      .fifo_empty (fifo_empty),
      .fifo_data  (fifo_data),
      .fifo_eom   (fifo_eom),
      .fifo_rd    (fifo_rd),
      .tx_bit     (tx_bit),
      .msg_done   (msg_done),
      .underrun   (underrun)
   );

   // ---------------- FIFO model ----------------
   logic [8:0] fmem [0:255];
   int rp = 0, wp = 0, npop = 0;
   logic pop_pend = 1'b0;
   assign fifo_empty = (rp == wp);
   assign fifo_data  = fmem[rp % 256][7:0];
   assign fifo_eom   = fmem[rp % 256][8];

   always @(posedge clk) pop_pend <= fifo_rd;

   // ---------------- capture ----------------
   bit   cap [0:32767];
   int   ncap = 0;
   int   md_pos [0:63];
   int   md_cnt = 0, ud_cnt = 0, hold_err = 0;
   bit   en_on = 0, en_mode = 0;
   logic [7:0] lfsr = 8'hA7;
   logic last_tx = 1'b1;
   int   cyc = 0;
   int   total = 0, bad = 0;

   initial bit_en = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (pop_pend) begin rp++; npop++; end
         if (!bit_en && tx_bit !== last_tx) hold_err++;
         if (bit_en) begin
            if (msg_done && md_cnt < 64) begin md_pos[md_cnt] = ncap; md_cnt++; end
            if (ncap < 32768) cap[ncap] = tx_bit;
            ncap++;
         end
         if (underrun) ud_cnt++;
      end
      last_tx = tx_bit;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      bit_en = en_on ? (en_mode ? lfsr[0] : 1'b1) : 1'b0;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog: run hung act=%0d exp<=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   logic [7:0] mb [0:63];
   int mlen;

   task automatic push_msg(input bit with_eom);
      for (int i = 0; i < mlen; i++) begin
         fmem[wp % 256] = {(with_eom && i == mlen - 1), mb[i]};
         wp++;
      end
   endtask

   function automatic logic [15:0] fcs16();
      logic [15:0] c = 16'hFFFF;
      for (int i = 0; i < mlen; i++)
         for (int b = 0; b < 8; b++) begin
            logic f;
            f = c[0] ^ mb[i][b];
            c = c >> 1;
            if (f) c = c ^ 16'h8408;
         end
      return ~c;
   endfunction

   // ---------------- independent line decoder ----------------
   logic [7:0] frm_b [0:31][0:63];
   int frm_len [0:31];
   int frm_close [0:31];
   int flag_end [0:4095];
   int nfrm, nflag, nabort, nbadlen;
   bit fb [0:1023];

   task automatic decode();
      int nb = 0, ones = 0;
      nfrm = 0; nflag = 0; nabort = 0; nbadlen = 0;
      for (int i = 0; i < ncap && i < 32768; i++) begin
         if (cap[i]) begin
            ones++;
            if (nb < 1024) begin fb[nb] = 1'b1; nb++; end
         end else if (ones == 5) begin
            ones = 0;
         end else if (ones == 6) begin
            nb = (nb >= 7) ? nb - 7 : 0;
            if (nb > 0) begin
               if (nb % 8 != 0 || nb / 8 > 64 || nfrm >= 32) nbadlen++;
               else begin
                  for (int j = 0; j < nb / 8; j++)
                     for (int k = 0; k < 8; k++) frm_b[nfrm][j][k] = fb[8*j+k];
                  frm_len[nfrm] = nb / 8;
                  frm_close[nfrm] = nflag;
                  nfrm++;
               end
            end
            if (nflag < 4096) flag_end[nflag] = i;
            nflag++;
            nb = 0; ones = 0;
         end else if (ones >= 7) begin
            nabort++;
            fb[0] = 1'b0; nb = 1; ones = 0;
         end else begin
            if (nb < 1024) begin fb[nb] = 1'b0; nb++; end
            ones = 0;
         end
      end
   endtask

   task automatic check_frame(input int k, input bit with_fcs, input string req);
      int exp_len, mism;
      logic [15:0] f;
      exp_len = mlen + (with_fcs ? 2 : 0);
      chk(frm_len[k] == exp_len, req, "frame length", frm_len[k], exp_len);
      mism = 0;
      for (int i = 0; i < mlen && i < frm_len[k]; i++)
         if (frm_b[k][i] != mb[i]) mism++;
      chk(mism == 0, req, "message byte mismatches", mism, 0);
      if (with_fcs && frm_len[k] == exp_len) begin
         f = fcs16();
         chk({frm_b[k][mlen+1], frm_b[k][mlen]} == f, "R5", "check octets",
             int'({frm_b[k][mlen+1], frm_b[k][mlen]}), int'(f));
      end
   endtask

   task automatic wait_md(input int target);
      int n = 0;
      while (md_cnt < target && n < 30000) begin @(negedge clk); n++; end
      repeat (80) @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      rst_n = 1'b0; fcs_en = 1'b1;
      repeat (5) @(negedge clk);
      chk(tx_bit === 1'b1, "R1", "tx_bit in reset", int'(tx_bit), 1);
      chk(fifo_rd === 1'b0, "R1", "fifo_rd in reset", int'(fifo_rd), 0);
      chk(msg_done === 1'b0 && underrun === 1'b0, "R1", "pulses in reset",
          int'({msg_done, underrun}), 0);
      rst_n = 1'b1;
      en_on = 1'b1;
   endtask

   task automatic t_idle();
      int mism = 0;
      repeat (64) @(negedge clk);
      decode();
      for (int i = 0; i < 16; i++)
         if (cap[i] != 1'(8'h7E >> (i % 8))) mism++;
      chk(mism == 0, "R2", "first flag bits", mism, 0);
      chk(nfrm == 0 && nabort == 0, "R2", "frames while idle", nfrm + nabort, 0);
      chk(nflag >= 7, "R2", "idle flag count", nflag, 7);
   endtask

   task automatic t_msg(input bit use_fcs, input string req);
      int f0, m0, p0;
      logic [7:0] pat [0:7] = '{8'h01, 8'hFF, 8'h7E, 8'h3E, 8'hA5, 8'h00, 8'hF8, 8'h1F};
      fcs_en = use_fcs;
      mlen = 8;
      for (int i = 0; i < 8; i++) mb[i] = pat[i] ^ (use_fcs ? 8'h00 : 8'h0F);
      decode(); f0 = nfrm; m0 = md_cnt; p0 = npop;
      push_msg(1'b1);
      wait_md(m0 + 1);
      decode();
      chk(nfrm == f0 + 1, req, "frames sent", nfrm - f0, 1);
      chk(npop - p0 == mlen, "R3", "bytes popped", npop - p0, mlen);
      if (nfrm == f0 + 1) begin
         check_frame(f0, use_fcs, req);
         chk(md_cnt == m0 + 1 && md_pos[m0] == flag_end[frm_close[f0] + 1],
             "R7", "msg_done bit position", md_pos[m0], flag_end[frm_close[f0] + 1]);
      end
   endtask

   task automatic t_b2b();
      int f0, m0;
      fcs_en = 1'b1;
      decode(); f0 = nfrm; m0 = md_cnt;
      mlen = 3; mb[0] = 8'hC3; mb[1] = 8'h7E; mb[2] = 8'h5A;
      push_msg(1'b1);
      mlen = 4; mb[0] = 8'h11; mb[1] = 8'hFF; mb[2] = 8'hFE; mb[3] = 8'h80;
      push_msg(1'b1);
      wait_md(m0 + 2);
      decode();
      chk(nfrm == f0 + 2, "R8", "back-to-back frames", nfrm - f0, 2);
      chk(md_cnt == m0 + 2, "R7", "msg_done pulses", md_cnt - m0, 2);
      if (nfrm == f0 + 2 && md_cnt == m0 + 2) begin
         check_frame(f0 + 1, 1'b1, "R4");
         chk(frm_close[f0+1] - frm_close[f0] == 2, "R8", "flags between frames",
             frm_close[f0+1] - frm_close[f0], 2);
         chk(md_pos[m0] == flag_end[frm_close[f0] + 1], "R7", "first done position",
             md_pos[m0], flag_end[frm_close[f0] + 1]);
         chk(nflag - frm_close[f0+1] > 2, "R8", "idle flags after last frame",
             nflag - frm_close[f0+1], 3);
      end
   endtask

   task automatic t_underrun();
      int f0, m0, u0, a0, g0, p0, n = 0;
      fcs_en = 1'b1;
      decode(); f0 = nfrm; m0 = md_cnt; u0 = ud_cnt; a0 = nabort; g0 = nflag; p0 = npop;
      mlen = 3; mb[0] = 8'h12; mb[1] = 8'h34; mb[2] = 8'h56;
      push_msg(1'b0);
      while (ud_cnt == u0 && n < 5000) begin @(negedge clk); n++; end
      repeat (80) @(negedge clk);
      decode();
      chk(ud_cnt == u0 + 1, "R10", "underrun pulses", ud_cnt - u0, 1);
      chk(nabort == a0 + 1, "R10", "aborts on line", nabort - a0, 1);
      chk(nfrm == f0 && md_cnt == m0, "R10", "frames or done after abort",
          (nfrm - f0) + (md_cnt - m0), 0);
      chk(npop - p0 == 3, "R3", "bytes popped before abort", npop - p0, 3);
      chk(nflag - g0 >= 3, "R10", "flags after abort", nflag - g0, 3);
   endtask

   task automatic t_gap();
      int f0, m0, h0;
      en_mode = 1'b1; fcs_en = 1'b1;
      decode(); f0 = nfrm; m0 = md_cnt; h0 = hold_err;
      mlen = 5; mb[0] = 8'hFF; mb[1] = 8'hFF; mb[2] = 8'h7E; mb[3] = 8'hFF; mb[4] = 8'h3F;
      push_msg(1'b1);
      wait_md(m0 + 1);
      decode();
      chk(nfrm == f0 + 1, "R9", "frame under gapped enable", nfrm - f0, 1);
      if (nfrm == f0 + 1) begin
         check_frame(f0, 1'b1, "R6");
         chk(md_pos[m0] == flag_end[frm_close[f0] + 1], "R7", "done position gapped",
             md_pos[m0], flag_end[frm_close[f0] + 1]);
      end
      chk(hold_err == h0, "R9", "tx_bit moved without bit_en", hold_err - h0, 0);
      en_mode = 1'b0;
   endtask

   initial begin
      t_reset();
      t_idle();
      t_msg(1'b1, "R4");
      t_msg(1'b0, "R5");
      t_b2b();
      t_underrun();
      t_msg(1'b1, "R6");
      t_gap();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule